// File: doc/BRIEF.md
# Configuration Transaction Control Engine

This block is a small command channel through which software reads and writes board configuration items, such as oscillator frequencies and supply-sensor voltages. The items live on a motherboard site or on a daughterboard site. Software sees three registers: a 32-bit data register, a 32-bit control word and a 2-bit status register. The surrounding register decoder presents each write on a select/data port. The current register contents are always visible on the outputs, so a read path needs no extra logic here.

Writing the control word with bit 31 set starts a transaction. The block splits the word into its controller, function, site, position and device fields and checks that the addressed item exists. Within the same write cycle it either fetches the item into the data register or stores the data register into the item. It also records done and error flags in the status register. A successful shutdown command or reboot command also raises a one-cycle request pulse.

Top module: `cfg_xact_engine`

## Requirements
- R1: After reset, the data register, the control word and the status register read 0, and both request outputs are low. The six motherboard oscillator entries hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. The daughterboard oscillator entries hold the values of the DB_OSC_RST parameter, with entry k in bits [32k+31:32k]. The default values are 40000000 and 33000000.
- R2: A write with `wr_sel`=1 stores the word as the control word, with bit 31 and bits [19:18] cleared. The fields are: bit 31 start, bit 30 write(1)/read(0), bits [29:26] controller, bits [25:20] function, bits [17:16] site, bits [15:12] position, bits [11:0] device. Without the start bit, the data and status registers are untouched.
- R3: A control write with the start bit set leaves the status at 1 (done) on the next cycle, or at 3 if the access is unsupported.
- R4: A nonzero controller, a nonzero position, or a site other than 0 (motherboard) or 1 (daughterboard) makes the transaction fail with status 3.
- R5: Function 1 reads or writes motherboard oscillator devices 0..5 or daughterboard oscillator devices 0..DB_OSC_NUM-1. A write stores the current data register. Any other device fails.
- R6: A function 2 read returns 3300000 for motherboard device 0, or DB_SENS_VAL entry k for daughterboard device k below DB_SENS_NUM. The default values are 900000 and 1000000. Any function 2 write fails.
- R7: A write of function 7, 8, 9 or 11 succeeds only for site 0, device 0. A read of these functions fails, as does any other function.
- R8: A successful function 8 write drives `shutdown_req` high, and a successful function 9 write drives `reboot_req` high. Each pulse lasts exactly the one cycle after the launching write.
- R9: A write with `wr_sel`=2 sets the status to bits [1:0] of the written word.
- R10: A write with `wr_sel`=0 loads the data register. A successful read loads the fetched value into it. A failed transaction leaves it unchanged.
- R11: A write with `wr_sel`=3 changes no register and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 data, 1 control, 2 status, 3 none |
| wr_data | input | 32 | Write data |
| data_q | output | 32 | Data register contents |
| ctrl_q | output | 32 | Stored control word |
| stat_q | output | 2 | Status: bit 0 done, bit 1 error |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The assertions assume that each write strobe is a single-cycle event whose select and data are stable around the clock edge. They also assume that a launching control write carries no meaningful reserved bits. Their checks compare the status and data registers with the word seen one cycle earlier. The bench holds `wr_en` high for exactly one cycle and leaves an idle cycle between writes. It drives on the falling edge and builds every launch word from the field layout in R2. This keeps every command inside those assumptions while still covering invalid controller, position and site codes.

// File: rtl/cfg_xact_pkg.sv
package cfg_xact_pkg;
  localparam int XW = 32;
  localparam int MB_OSC_NUM = 6;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int B_GO  = 31;
  localparam int B_WR  = 30;
  localparam int B_CTL = 26;
  localparam int B_FN  = 20;
  localparam int B_ST  = 16;
  localparam int B_POS = 12;

  localparam logic [XW-1:0] CTRL_KEEP = 32'h7FF3_FFFF;

  localparam logic [5:0] FN_OSC  = 6'd1;
  localparam logic [5:0] FN_VOLT = 6'd2;
  localparam logic [5:0] FN_VMUX = 6'd7;
  localparam logic [5:0] FN_SHUT = 6'd8;
  localparam logic [5:0] FN_BOOT = 6'd9;
  localparam logic [5:0] FN_DISP = 6'd11;

  localparam logic [XW-1:0] MB_VIO = 32'd3300000;

  function automatic logic [XW-1:0] mb_osc_reset(int idx);
    case (idx)
      0:       return 32'd50000000;
      1:       return 32'd23750000;
      default: return 32'd24000000;
    endcase
  endfunction
endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_xact_pkg::*;
#(
  parameter int DB_OSC_NUM  = 2,
  parameter int DB_SENS_NUM = 2,
  localparam int OSC_TOT = MB_OSC_NUM + DB_OSC_NUM,
  localparam int IDXW    = $clog2(OSC_TOT),
  localparam int SIDXW   = (DB_SENS_NUM > 1) ? $clog2(DB_SENS_NUM) : 1
) (
  input  logic [3:0]       ctl,
  input  logic [5:0]       fn,
  input  logic [1:0]       site,
  input  logic [3:0]       pos,
  input  logic [11:0]      dev,
  output logic             osc_hit,
  output logic [IDXW-1:0]  osc_idx,
  output logic             sens_hit,
  output logic [SIDXW-1:0] sens_idx,
  output logic             mb_volt,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             do_shut,
  output logic             do_boot
);
  localparam logic [11:0] MB_LIM   = 12'(MB_OSC_NUM);
  localparam logic [11:0] DB_LIM   = 12'(DB_OSC_NUM);
  localparam logic [11:0] SENS_LIM = 12'(DB_SENS_NUM);

  logic base_ok, on_mb, on_db, mb_dev0, sys_hit;

  always_comb begin
    base_ok = (ctl == 4'd0) && (pos == 4'd0) && (site[1] == 1'b0);
    on_mb   = base_ok && (site == 2'd0);
    on_db   = base_ok && (site == 2'd1);
    mb_dev0 = on_mb && (dev == 12'd0);

    osc_hit = (fn == FN_OSC) &&
              ((on_mb && (dev < MB_LIM)) || (on_db && (dev < DB_LIM)));
    osc_idx = IDXW'(dev) + (on_mb ? IDXW'(0) : IDXW'(MB_OSC_NUM));

    sens_hit = (fn == FN_VOLT) && on_db && (dev < SENS_LIM);
    sens_idx = SIDXW'(dev);
    mb_volt  = (fn == FN_VOLT) && mb_dev0;

    sys_hit = mb_dev0 && ((fn == FN_VMUX) || (fn == FN_SHUT) ||
                          (fn == FN_BOOT) || (fn == FN_DISP));
    do_shut = mb_dev0 && (fn == FN_SHUT);
    do_boot = mb_dev0 && (fn == FN_BOOT);

    rd_ok = osc_hit || sens_hit || mb_volt;
    wr_ok = osc_hit || sys_hit;
  end
endmodule

// File: rtl/cfg_osc_table.sv
module cfg_osc_table
  import cfg_xact_pkg::*;
#(
  parameter int DB_OSC_NUM = 2,
  parameter logic [DB_OSC_NUM*XW-1:0] DB_OSC_RST = {32'd33000000, 32'd40000000},
  localparam int OSC_TOT = MB_OSC_NUM + DB_OSC_NUM,
  localparam int IDXW    = $clog2(OSC_TOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [XW-1:0]   wdata,
  output logic [XW-1:0]   rdata
);
  logic [XW-1:0] ent_q [OSC_TOT];

  for (genvar i = 0; i < OSC_TOT; i++) begin : g_ent
    logic en;
    assign en = we && (idx == IDXW'(i));
    if (i < MB_OSC_NUM) begin : g_mb
      localparam logic [XW-1:0] RV = mb_osc_reset(i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ent_q[i] <= RV;
        else if (en) ent_q[i] <= wdata;
      end
    end else begin : g_db
      localparam logic [XW-1:0] RV = DB_OSC_RST[(i-MB_OSC_NUM)*XW +: XW];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ent_q[i] <= RV;
        else if (en) ent_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < OSC_TOT; i++) begin
      if (idx == IDXW'(i)) rdata = ent_q[i];
    end
  end
endmodule

// File: rtl/cfg_sens_lookup.sv
module cfg_sens_lookup
  import cfg_xact_pkg::*;
#(
  parameter int DB_SENS_NUM = 2,
  parameter logic [DB_SENS_NUM*XW-1:0] DB_SENS_VAL = {32'd1000000, 32'd900000},
  localparam int SIDXW = (DB_SENS_NUM > 1) ? $clog2(DB_SENS_NUM) : 1
) (
  input  logic             mb_sel,
  input  logic [SIDXW-1:0] idx,
  output logic [XW-1:0]    value
);
  always_comb begin
    value = '0;
    for (int k = 0; k < DB_SENS_NUM; k++) begin
      if (idx == SIDXW'(k)) value = DB_SENS_VAL[k*XW +: XW];
    end
    if (mb_sel) value = MB_VIO;
  end
endmodule

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine
  import cfg_xact_pkg::*;
#(
  parameter int DB_OSC_NUM  = 2,
  parameter int DB_SENS_NUM = 2,
  parameter logic [DB_OSC_NUM*32-1:0]  DB_OSC_RST  = {32'd33000000, 32'd40000000},
  parameter logic [DB_SENS_NUM*32-1:0] DB_SENS_VAL = {32'd1000000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] data_q,
  output logic [31:0] ctrl_q,
  output logic [1:0]  stat_q,
  output logic        shutdown_req,
  output logic        reboot_req
);
  localparam int OSC_TOT = MB_OSC_NUM + DB_OSC_NUM;
  localparam int IDXW    = $clog2(OSC_TOT);
  localparam int SIDXW   = (DB_SENS_NUM > 1) ? $clog2(DB_SENS_NUM) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic             osc_hit, sens_hit, mb_volt, rd_ok, wr_ok, do_shut, do_boot;
  logic [IDXW-1:0]  osc_idx;
  logic [SIDXW-1:0] sens_idx;
  logic [XW-1:0]    osc_rdata, sens_val;

  cfg_cmd_decode #(.DB_OSC_NUM(DB_OSC_NUM), .DB_SENS_NUM(DB_SENS_NUM)) i_dec (
    .ctl(wr_data[B_CTL +: 4]), .fn(wr_data[B_FN +: 6]), .site(wr_data[B_ST +: 2]),
    .pos(wr_data[B_POS +: 4]), .dev(wr_data[11:0]),
    .osc_hit(osc_hit), .osc_idx(osc_idx), .sens_hit(sens_hit), .sens_idx(sens_idx),
    .mb_volt(mb_volt), .rd_ok(rd_ok), .wr_ok(wr_ok), .do_shut(do_shut), .do_boot(do_boot)
  );

  // launch-phase strobes
  logic wr_data_reg, wr_ctrl_reg, wr_stat_reg, launch, is_wr, xact_ok;
  logic osc_we;
  always_comb begin
    wr_data_reg = wr_en && (wr_sel == SEL_DATA);
    wr_ctrl_reg = wr_en && (wr_sel == SEL_CTRL);
    wr_stat_reg = wr_en && (wr_sel == SEL_STAT);
    launch      = wr_ctrl_reg && wr_data[B_GO];
    is_wr       = wr_data[B_WR];
    xact_ok     = is_wr ? wr_ok : rd_ok;
    osc_we      = launch && is_wr && osc_hit;
  end

  cfg_osc_table #(.DB_OSC_NUM(DB_OSC_NUM), .DB_OSC_RST(DB_OSC_RST)) i_osc (
    .clk(clk), .rst_n(rst_ns), .we(osc_we), .idx(osc_idx), .wdata(data_q), .rdata(osc_rdata)
  );

  cfg_sens_lookup #(.DB_SENS_NUM(DB_SENS_NUM), .DB_SENS_VAL(DB_SENS_VAL)) i_sens (
    .mb_sel(mb_volt), .idx(sens_idx), .value(sens_val)
  );

  // next state
  logic [XW-1:0] data_d, ctrl_d;
  logic [1:0]    stat_d;
  logic          data_en, ctrl_en, stat_en, shut_d, boot_d;
  always_comb begin
    data_en = wr_data_reg || (launch && !is_wr && rd_ok);
    data_d  = wr_data_reg ? wr_data : (osc_hit ? osc_rdata : sens_val);
    ctrl_en = wr_ctrl_reg;
    ctrl_d  = wr_data & CTRL_KEEP;
    stat_en = launch || wr_stat_reg;
    stat_d  = launch ? {~xact_ok, 1'b1} : wr_data[1:0];
    shut_d  = launch && is_wr && do_shut;
    boot_d  = launch && is_wr && do_boot;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      data_q       <= '0;
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (stat_en) stat_q <= stat_d;
      shutdown_req <= shut_d;
      reboot_req   <= boot_d;
    end
  end

  AST_LAUNCH_DONE: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_sel == SEL_CTRL && wr_data[31]) |=> stat_q[0]); // R3
  AST_BAD_CTL_ERR: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_sel == SEL_CTRL && wr_data[31] && wr_data[29:26] != 4'd0)
      |=> (stat_q == 2'd3)); // R4
  AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_sel == SEL_STAT) |=> (stat_q == $past(wr_data[1:0]))); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_sel == SEL_CTRL && !wr_data[31]) |=> $stable(data_q)); // R2
  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_ns)
    shutdown_req |-> $past(wr_en && wr_sel == SEL_CTRL && wr_data[31:30] == 2'b11
                           && wr_data[25:20] == FN_SHUT)); // R8
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_ns)
    !(shutdown_req && reboot_req)); // R8
  AST_NONE_SEL: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(stat_q))); // R11
endmodule

// File: tb/test_cfg_xact_engine.sv
module test_cfg_xact_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic        shutdown_req, reboot_req;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfg_xact_engine i_cfg_xact_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_q(data_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  task automatic put(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] cmd(input bit w, input int fn, input int site,
                                      input int pos, input int ctl, input int dev);
    return {1'b1, w, 4'(ctl), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  task automatic t_reset;
    chk(data_q == 0, "R1 data reset", data_q, 0);
    chk(ctrl_q == 0, "R1 ctrl reset", ctrl_q, 0);
    chk(stat_q == 0, "R1 stat reset", 32'(stat_q), 0);
    chk(!shutdown_req && !reboot_req, "R1 requests low", 32'({shutdown_req, reboot_req}), 0);
  endtask

  task automatic t_mb_osc;
    logic [31:0] exp [6] = '{50000000, 23750000, 24000000, 24000000, 24000000, 24000000};
    for (int d = 0; d < 6; d++) begin
      put(2'd1, cmd(0, 1, 0, 0, 0, d));
      chk(data_q == exp[d], "R1 R5 mb osc read", data_q, exp[d]);
      chk(stat_q == 2'd1, "R3 done no error", 32'(stat_q), 1);
    end
    put(2'd0, 32'd12345678);
    put(2'd1, cmd(1, 1, 0, 0, 0, 5));
    chk(stat_q == 2'd1, "R5 mb osc write ok", 32'(stat_q), 1);
    put(2'd0, 32'd0);
    put(2'd1, cmd(0, 1, 0, 0, 0, 5));
    chk(data_q == 32'd12345678, "R5 mb osc readback", data_q, 12345678);
    put(2'd1, cmd(0, 1, 0, 0, 0, 6));
    chk(stat_q == 2'd3, "R5 mb osc dev6 error", 32'(stat_q), 3);
    chk(data_q == 32'd12345678, "R10 failed read keeps data", data_q, 12345678);
  endtask

  task automatic t_db_osc;
    put(2'd1, cmd(0, 1, 1, 0, 0, 0));
    chk(data_q == 32'd40000000, "R1 db osc0 reset", data_q, 40000000);
    put(2'd1, cmd(0, 1, 1, 0, 0, 1));
    chk(data_q == 32'd33000000, "R1 db osc1 reset", data_q, 33000000);
    put(2'd0, 32'd777);
    chk(data_q == 32'd777, "R10 data write", data_q, 777);
    put(2'd1, cmd(1, 1, 1, 0, 0, 1));
    chk(stat_q == 2'd1, "R5 db osc write ok", 32'(stat_q), 1);
    put(2'd1, cmd(0, 1, 1, 0, 0, 0));
    put(2'd1, cmd(0, 1, 1, 0, 0, 1));
    chk(data_q == 32'd777, "R5 db osc readback", data_q, 777);
    put(2'd1, cmd(0, 1, 1, 0, 0, 2));
    chk(stat_q == 2'd3, "R5 db osc dev2 error", 32'(stat_q), 3);
  endtask

  task automatic t_volt;
    put(2'd1, cmd(0, 2, 0, 0, 0, 0));
    chk(data_q == 32'd3300000, "R6 mb volt", data_q, 3300000);
    chk(stat_q == 2'd1, "R6 mb volt ok", 32'(stat_q), 1);
    put(2'd1, cmd(0, 2, 1, 0, 0, 1));
    chk(data_q == 32'd1000000, "R6 db sensor1", data_q, 1000000);
    put(2'd1, cmd(0, 2, 1, 0, 0, 2));
    chk(stat_q == 2'd3, "R6 db sensor2 error", 32'(stat_q), 3);
    put(2'd1, cmd(0, 2, 0, 0, 0, 1));
    chk(stat_q == 2'd3, "R6 mb volt dev1 error", 32'(stat_q), 3);
    put(2'd1, cmd(1, 2, 0, 0, 0, 0));
    chk(stat_q == 2'd3, "R6 volt write error", 32'(stat_q), 3);
  endtask

  task automatic t_bad_fields;
    put(2'd0, 32'hABCD);
    put(2'd1, cmd(0, 1, 0, 0, 1, 0));
    chk(stat_q == 2'd3, "R4 controller 1", 32'(stat_q), 3);
    put(2'd1, cmd(0, 1, 0, 1, 0, 0));
    chk(stat_q == 2'd3, "R4 position 1", 32'(stat_q), 3);
    put(2'd1, cmd(0, 1, 2, 0, 0, 0));
    chk(stat_q == 2'd3, "R4 site 2", 32'(stat_q), 3);
    put(2'd1, cmd(0, 2, 3, 0, 0, 0));
    chk(stat_q == 2'd3, "R4 site 3", 32'(stat_q), 3);
    chk(data_q == 32'hABCD, "R10 R4 data unchanged", data_q, 32'hABCD);
  endtask

  task automatic t_ctrl_word;
    put(2'd2, 32'd0);
    put(2'd1, 32'h7FFF_FFFF);
    chk(ctrl_q == 32'h7FF3_FFFF, "R2 reserved cleared", ctrl_q, 32'h7FF3_FFFF);
    chk(stat_q == 2'd0, "R2 no launch keeps status", 32'(stat_q), 0);
    chk(data_q == 32'hABCD, "R2 no launch keeps data", data_q, 32'hABCD);
    put(2'd1, cmd(0, 1, 0, 0, 0, 2) | 32'h000C_0000);
    chk(ctrl_q == 32'h0010_0002, "R2 start not stored", ctrl_q, 32'h0010_0002);
    chk(data_q == 32'd24000000, "R2 launch with reserved bits", data_q, 24000000);
  endtask

  task automatic t_sys;
    put(2'd1, cmd(1, 7, 0, 0, 0, 0));
    chk(stat_q == 2'd1, "R7 video mux ok", 32'(stat_q), 1);
    chk(!shutdown_req && !reboot_req, "R8 no pulse on mux", 32'({shutdown_req, reboot_req}), 0);
    put(2'd1, cmd(1, 11, 0, 0, 0, 0));
    chk(stat_q == 2'd1, "R7 display mode ok", 32'(stat_q), 1);
    put(2'd1, cmd(1, 8, 0, 0, 0, 0));
    chk(stat_q == 2'd1, "R7 shutdown ok", 32'(stat_q), 1);
    chk(shutdown_req && !reboot_req, "R8 shutdown pulse", 32'({shutdown_req, reboot_req}), 2);
    @(negedge clk);
    chk(!shutdown_req, "R8 shutdown one cycle", 32'(shutdown_req), 0);
    put(2'd1, cmd(1, 9, 0, 0, 0, 0));
    chk(reboot_req && !shutdown_req, "R8 reboot pulse", 32'({shutdown_req, reboot_req}), 1);
    @(negedge clk);
    chk(!reboot_req, "R8 reboot one cycle", 32'(reboot_req), 0);
    put(2'd1, cmd(1, 8, 0, 0, 0, 1));
    chk(stat_q == 2'd3, "R7 shutdown dev1 error", 32'(stat_q), 3);
    chk(!shutdown_req, "R8 no pulse on failed shutdown", 32'(shutdown_req), 0);
    put(2'd1, cmd(1, 9, 1, 0, 0, 0));
    chk(stat_q == 2'd3, "R7 reboot site1 error", 32'(stat_q), 3);
    chk(!reboot_req, "R8 no pulse on failed reboot", 32'(reboot_req), 0);
    put(2'd1, cmd(0, 8, 0, 0, 0, 0));
    chk(stat_q == 2'd3 && !shutdown_req, "R7 shutdown read error", 32'(stat_q), 3);
    put(2'd1, cmd(1, 3, 0, 0, 0, 0));
    chk(stat_q == 2'd3, "R7 unknown function error", 32'(stat_q), 3);
  endtask

  task automatic t_stat;
    put(2'd2, 32'hFFFF_FFFE);
    chk(stat_q == 2'd2, "R9 status low bits", 32'(stat_q), 2);
    put(2'd2, 32'h0000_0005);
    chk(stat_q == 2'd1, "R9 status low bits 2", 32'(stat_q), 1);
  endtask

  task automatic t_ignore;
    logic [31:0] d0, c0;
    logic [1:0]  s0;
    d0 = data_q; c0 = ctrl_q; s0 = stat_q;
    put(2'd3, cmd(1, 8, 0, 0, 0, 0));
    chk(data_q == d0 && ctrl_q == c0, "R11 regs unchanged", data_q, d0);
    chk(stat_q == s0, "R11 status unchanged", 32'(stat_q), 32'(s0));
    chk(!shutdown_req, "R11 no request", 32'(shutdown_req), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mb_osc();
    t_db_osc();
    t_volt();
    t_bad_fields();
    t_ctrl_word();
    t_sys();
    t_stat();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule